// File: doc/BRIEF.md
# Event-Triggered Single-Channel Byte Mover

This block is one channel of a byte-copy engine. It moves data from a source buffer to a destination buffer with no processor involvement. Each buffer is described by a start address and a size in bytes. The channel keeps one running offset into each buffer, and each offset wraps at the size of its own buffer. A trigger moves one cell of bytes. The trigger is either a software strobe or a selected line of the interrupt-request vector. Moving a cell takes one memory transaction per byte, one transaction per clock. In each transaction the channel reads a byte at source start plus source offset and writes the same byte to destination start plus destination offset.

A block ends after the larger of the two sizes has been moved. The offsets then return to zero. If auto-enable is clear, the channel also disarms itself; if it is set, the channel stays armed. The channel stops early (aborts) on any of these:
- the abort strobe;
- a selected abort interrupt line;
- a bus address error;
- a written byte that equals a programmed pattern.

When an abort hits, the transaction already on the bus completes first. One-cycle event pulses report the half points, the wrap points, the end of a block and aborts.

Top module: `evdma_channel`

## Requirements
- R1: A memory transaction (`mem_en`=1) happens only while `ctl_on`=1, the channel is armed (`ch_enabled`=1) and `ctl_susp`=0. After reset both offsets are 0, the channel is disarmed and `mem_en`=0.
- R2: While the channel is idle, enabled and not suspended, a cell starts on `force_go`=1, or on `irq_vec[start_sel]`=1 with `start_irq_en`=1. A trigger that arrives while a cell is moving is ignored, and each trigger moves exactly `cell_size` bytes.
- R3: A cell starts in the cycle after its trigger and moves one byte per cycle. Each transaction reads `src_base+src_ptr`, writes the byte read to `dst_base+dst_ptr`, then advances each offset by one. An offset that reaches its own buffer size wraps to 0.
- R4: The offsets change only through a transaction or one of the clearing events in R7 to R10.
- R5: `src_half` (or `dst_half`) pulses for one cycle, one cycle after the transaction that brings that offset to its size shifted right by one. It pulses only when that value is nonzero.
- R6: `src_done` (or `dst_done`) pulses for one cycle, one cycle after the transaction that brings that offset to its own size.
- R7: When the larger of `src_size` and `dst_size` bytes have moved since the last clear, both offsets clear and `blk_done` pulses. The channel disarms if `auto_en`=0 and stays armed if `auto_en`=1.
- R8: `ctl_on`=0 clears both offsets in the next cycle and returns the channel to idle.
- R9: A pulse on `src_base_wr` clears only the source offset. A pulse on `dst_base_wr` clears only the destination offset.
- R10: Each of the following aborts the channel:
  - `abort_go`;
  - `irq_vec[abort_sel]` with `abort_irq_en`=1 while the channel is armed or mid-cell;
  - `mem_addr_err`=1 during a transaction;
  - with `pat_en`=1 and `auto_en`=0, a written byte equal to `pat_val`.

  Any transaction in that cycle still completes. The channel then disarms, clears both offsets and pulses `abort_flag` in the next cycle.
- R11: With `pat_en`=1 and `auto_en`=1, a written byte equal to `pat_val` ends the block. Both offsets clear, the channel stays armed, and no abort is flagged.
- R12: An abort that arrives while `ctl_susp`=1, or while a cell is stalled by a disarmed channel, keeps both offsets. It still disarms the channel and pulses `abort_flag`.
- R13: If the channel is disarmed in the middle of a cell, transfers stall. Re-arming resumes the remaining bytes of that cell without a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ctl_on | input | 1 | global controller enable |
| ctl_susp | input | 1 | global suspend |
| ch_arm | input | 1 | strobe: arm channel |
| ch_disarm | input | 1 | strobe: disarm channel |
| auto_en | input | 1 | stay armed after a block ends |
| src_base | input | ADDR_W | source start address |
| src_base_wr | input | 1 | strobe: source start address rewritten |
| dst_base | input | ADDR_W | destination start address |
| dst_base_wr | input | 1 | strobe: destination start address rewritten |
| src_size | input | SIZE_W | source size in bytes (nonzero) |
| dst_size | input | SIZE_W | destination size in bytes (nonzero) |
| cell_size | input | SIZE_W | bytes per trigger (nonzero) |
| start_sel | input | SEL_W | start interrupt index |
| start_irq_en | input | 1 | enable start by interrupt |
| abort_sel | input | SEL_W | abort interrupt index |
| abort_irq_en | input | 1 | enable abort by interrupt |
| pat_en | input | 1 | enable pattern stop |
| pat_val | input | 8 | pattern byte |
| force_go | input | 1 | strobe: software start |
| abort_go | input | 1 | strobe: software abort |
| irq_vec | input | NUM_IRQ | interrupt request lines |
| mem_en | output | 1 | read and write transaction this cycle |
| mem_rd_addr | output | ADDR_W | read byte address |
| mem_rd_data | input | 8 | byte read (combinational) |
| mem_wr_addr | output | ADDR_W | write byte address |
| mem_wr_data | output | 8 | byte written |
| mem_addr_err | input | 1 | address error for this transaction |
| src_ptr | output | SIZE_W | source offset |
| dst_ptr | output | SIZE_W | destination offset |
| src_half | output | 1 | pulse: source offset at half size |
| dst_half | output | 1 | pulse: destination offset at half size |
| src_done | output | 1 | pulse: source offset reached size |
| dst_done | output | 1 | pulse: destination offset reached size |
| blk_done | output | 1 | pulse: block completed |
| abort_flag | output | 1 | pulse: channel aborted |
| ch_enabled | output | 1 | channel armed |

## Verification
The bench builds the channel with a 6-bit size field, 16-bit addresses and 8 interrupt lines. It uses a source of 6 bytes and a destination of 4 bytes, so the two offsets wrap at different points and a block spans several cells. With these small sizes, every half, wrap and block end, each abort cause, the suspend exception and a mid-cell stall are all reached within a few dozen cycles. The memory returns a byte computed from its address, so the pattern byte and the faulting address can each be placed on a chosen transaction.

// File: rtl/evdma_pkg.sv
package evdma_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_MOVE = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic half;
        logic done;
    } ptr_evt_s;

    typedef struct packed {
        logic start_hit;
        logic abort_ev;
        logic pat_end;
    } trig_s;

    function automatic logic [31:0] max_len(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/evdma_ptr.sv
module evdma_ptr
    import evdma_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SIZE_W-1:0] size,
    input  logic              step,
    input  logic              clr,
    output logic [SIZE_W-1:0] ptr,
    output ptr_evt_s          evt
);
    logic [SIZE_W-1:0] ptr_q;
    logic [SIZE_W-1:0] nxt;
    logic [SIZE_W-1:0] half_pt;
    logic              wrap;

    assign nxt     = ptr_q + 1'b1;
    assign half_pt = size >> 1;
    assign wrap    = (nxt == size);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            evt   <= '0;
        end else begin
            evt.half <= step && (half_pt != '0) && (nxt == half_pt);
            evt.done <= step && wrap;
            if (clr)
                ptr_q <= '0;
            else if (step)
                ptr_q <= wrap ? '0 : nxt;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/evdma_seq.sv
module evdma_seq #(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              cell_clr,
    input  logic              blk_clr,
    input  logic [SIZE_W-1:0] cell_size,
    input  logic [SIZE_W-1:0] blk_len,
    output logic              cell_last,
    output logic              blk_last
);
    logic [SIZE_W-1:0] cell_cnt;
    logic [SIZE_W-1:0] blk_cnt;
    logic [SIZE_W-1:0] cell_inc;
    logic [SIZE_W-1:0] blk_inc;

    assign cell_inc  = cell_cnt + 1'b1;
    assign blk_inc   = blk_cnt + 1'b1;
    assign cell_last = (cell_inc == cell_size);
    assign blk_last  = (blk_inc == blk_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_cnt <= '0;
            blk_cnt  <= '0;
        end else begin
            if (cell_clr)  cell_cnt <= '0;
            else if (step) cell_cnt <= cell_inc;
            if (blk_clr)   blk_cnt  <= '0;
            else if (step) blk_cnt  <= blk_inc;
        end
    end
endmodule

// File: rtl/evdma_trig.sv
module evdma_trig
    import evdma_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_IRQ-1:0] irq_vec,
    input  logic [SEL_W-1:0]   start_sel,
    input  logic               start_irq_en,
    input  logic [SEL_W-1:0]   abort_sel,
    input  logic               abort_irq_en,
    input  logic               force_go,
    input  logic               abort_go,
    input  logic               chan_live,
    input  logic               txn,
    input  logic [7:0]         rd_byte,
    input  logic               pat_en,
    input  logic [7:0]         pat_val,
    input  logic               addr_err,
    input  logic               auto_en,
    output trig_s              trig
);
    logic match;
    logic irq_abort;

    assign match     = txn && pat_en && (rd_byte == pat_val);
    assign irq_abort = abort_irq_en && irq_vec[abort_sel] && chan_live;

    always_comb begin
        trig.start_hit = force_go || (start_irq_en && irq_vec[start_sel]);
        trig.abort_ev  = abort_go || irq_abort || (txn && addr_err) || (match && !auto_en);
        trig.pat_end   = match && auto_en;
    end
endmodule

// File: rtl/evdma_channel.sv
module evdma_channel
    import evdma_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SIZE_W  = 8,
    parameter int NUM_IRQ = 16,
    localparam int SEL_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_on,
    input  logic               ctl_susp,
    input  logic               ch_arm,
    input  logic               ch_disarm,
    input  logic               auto_en,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic               src_base_wr,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic               dst_base_wr,
    input  logic [SIZE_W-1:0]  src_size,
    input  logic [SIZE_W-1:0]  dst_size,
    input  logic [SIZE_W-1:0]  cell_size,
    input  logic [SEL_W-1:0]   start_sel,
    input  logic               start_irq_en,
    input  logic [SEL_W-1:0]   abort_sel,
    input  logic               abort_irq_en,
    input  logic               pat_en,
    input  logic [7:0]         pat_val,
    input  logic               force_go,
    input  logic               abort_go,
    input  logic [NUM_IRQ-1:0] irq_vec,
    output logic               mem_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [7:0]         mem_rd_data,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [7:0]         mem_wr_data,
    input  logic               mem_addr_err,
    output logic [SIZE_W-1:0]  src_ptr,
    output logic [SIZE_W-1:0]  dst_ptr,
    output logic               src_half,
    output logic               dst_half,
    output logic               src_done,
    output logic               dst_done,
    output logic               blk_done,
    output logic               abort_flag,
    output logic               ch_enabled
);
    localparam int NSIDE = 2;

    ch_state_e         state;
    logic              ch_en_q;
    logic              run_ok;
    logic              txn;
    logic              keep;
    logic              blk_end;
    logic              ptr_clr;
    logic              cell_last;
    logic              blk_last;
    logic [SIZE_W-1:0] blk_len;
    trig_s             trig;

    logic [SIZE_W-1:0] sz_a  [NSIDE];
    logic [SIZE_W-1:0] ptr_a [NSIDE];
    logic              clr_a [NSIDE];
    ptr_evt_s          evt_a [NSIDE];

    assign run_ok  = ctl_on && ch_en_q && !ctl_susp;
    assign txn     = (state == CH_MOVE) && run_ok;
    assign keep    = ctl_susp || ((state == CH_MOVE) && !ch_en_q);
    assign blk_len = SIZE_W'(max_len(32'(src_size), 32'(dst_size)));
    assign blk_end = txn && blk_last && !trig.abort_ev;
    assign ptr_clr = !ctl_on || blk_end || trig.pat_end || (trig.abort_ev && !keep);

    evdma_trig #(.NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) u_trig (
        .irq_vec      (irq_vec),
        .start_sel    (start_sel),
        .start_irq_en (start_irq_en),
        .abort_sel    (abort_sel),
        .abort_irq_en (abort_irq_en),
        .force_go     (force_go),
        .abort_go     (abort_go),
        .chan_live    (ch_en_q || (state == CH_MOVE)),
        .txn          (txn),
        .rd_byte      (mem_rd_data),
        .pat_en       (pat_en),
        .pat_val      (pat_val),
        .addr_err     (mem_addr_err),
        .auto_en      (auto_en),
        .trig         (trig)
    );

    evdma_seq #(.SIZE_W(SIZE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .step      (txn),
        .cell_clr  (ptr_clr || (txn && cell_last)),
        .blk_clr   (ptr_clr),
        .cell_size (cell_size),
        .blk_len   (blk_len),
        .cell_last (cell_last),
        .blk_last  (blk_last)
    );

    assign sz_a[0]  = src_size;
    assign sz_a[1]  = dst_size;
    assign clr_a[0] = ptr_clr || src_base_wr;
    assign clr_a[1] = ptr_clr || dst_base_wr;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        evdma_ptr #(.SIZE_W(SIZE_W)) u_ptr (
            .clk  (clk),
            .rst  (rst),
            .size (sz_a[g]),
            .step (txn),
            .clr  (clr_a[g]),
            .ptr  (ptr_a[g]),
            .evt  (evt_a[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CH_IDLE;
            ch_en_q    <= 1'b0;
            blk_done   <= 1'b0;
            abort_flag <= 1'b0;
        end else begin
            blk_done   <= blk_end;
            abort_flag <= trig.abort_ev;

            if (ch_arm)
                ch_en_q <= 1'b1;
            else if (ch_disarm || trig.abort_ev || (blk_end && !auto_en))
                ch_en_q <= 1'b0;

            if (!ctl_on || trig.abort_ev || blk_end || trig.pat_end || (txn && cell_last))
                state <= CH_IDLE;
            else if ((state == CH_IDLE) && run_ok && trig.start_hit)
                state <= CH_MOVE;
        end
    end

    assign mem_en      = txn;
    assign mem_rd_addr = src_base + ADDR_W'(ptr_a[0]);
    assign mem_wr_addr = dst_base + ADDR_W'(ptr_a[1]);
    assign mem_wr_data = mem_rd_data;
    assign src_ptr     = ptr_a[0];
    assign dst_ptr     = ptr_a[1];
    assign src_half    = evt_a[0].half;
    assign src_done    = evt_a[0].done;
    assign dst_half    = evt_a[1].half;
    assign dst_done    = evt_a[1].done;
    assign ch_enabled  = ch_en_q;
endmodule

// File: rtl/evdma_chk.sv
module evdma_chk #(
    parameter int SIZE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_on,
    input logic              ctl_susp,
    input logic              ch_enabled,
    input logic              ch_arm,
    input logic              auto_en,
    input logic              mem_en,
    input logic              mem_addr_err,
    input logic              abort_go,
    input logic              abort_irq_en,
    input logic              src_base_wr,
    input logic              dst_base_wr,
    input logic [SIZE_W-1:0] src_ptr,
    input logic [SIZE_W-1:0] dst_ptr,
    input logic              abort_flag,
    input logic              blk_done
);
    p_gate_r1: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (ctl_on && ch_enabled && !ctl_susp));

    p_src_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_on && !mem_en && !abort_go && !abort_irq_en && !src_base_wr) |=> $stable(src_ptr));

    p_dst_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_on && !mem_en && !abort_go && !abort_irq_en && !dst_base_wr) |=> $stable(dst_ptr));

    p_blk_disarm_r7: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !$past(auto_en) && !$past(ch_arm)) |-> !ch_enabled);

    p_off_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_on |=> (src_ptr == '0 && dst_ptr == '0));

    p_src_base_r9: assert property (@(posedge clk) disable iff (rst)
        src_base_wr |=> (src_ptr == '0));

    p_abort_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        abort_go |=> abort_flag);

    p_err_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_addr_err && !ch_arm) |=> (abort_flag && !ch_enabled));
endmodule

bind evdma_channel evdma_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_on       (ctl_on),
    .ctl_susp     (ctl_susp),
    .ch_enabled   (ch_enabled),
    .ch_arm       (ch_arm),
    .auto_en      (auto_en),
    .mem_en       (mem_en),
    .mem_addr_err (mem_addr_err),
    .abort_go     (abort_go),
    .abort_irq_en (abort_irq_en),
    .src_base_wr  (src_base_wr),
    .dst_base_wr  (dst_base_wr),
    .src_ptr      (src_ptr),
    .dst_ptr      (dst_ptr),
    .abort_flag   (abort_flag),
    .blk_done     (blk_done)
);

// File: tb/sim_evdma_channel.sv
module sim_evdma_channel;
    localparam int AW = 16;
    localparam int SW = 6;
    localparam int NI = 8;
    localparam int SL = $clog2(NI);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_on = 0, ctl_susp = 0, ch_arm = 0, ch_disarm = 0, auto_en = 0;
    logic [AW-1:0] src_base = 16'h0100, dst_base = 16'h0200;
    logic src_base_wr = 0, dst_base_wr = 0;
    logic [SW-1:0] src_size = 6'd6, dst_size = 6'd4, cell_size = 6'd3;
    logic [SL-1:0] start_sel = '0, abort_sel = '0;
    logic start_irq_en = 0, abort_irq_en = 0, pat_en = 0;
    logic [7:0] pat_val = 8'h00;
    logic force_go = 0, abort_go = 0;
    logic [NI-1:0] irq_vec = '0;
    logic mem_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0] mem_rd_data, mem_wr_data;
    logic mem_addr_err;
    logic err_arm = 0;
    logic [AW-1:0] err_addr = '0;
    logic [SW-1:0] src_ptr, dst_ptr;
    logic src_half, dst_half, src_done, dst_done, blk_done, abort_flag, ch_enabled;

    always #4 clk = ~clk;

    assign mem_rd_data  = mem_rd_addr[7:0] ^ 8'h5A;
    assign mem_addr_err = err_arm && (mem_rd_addr == err_addr);

    evdma_channel #(.ADDR_W(AW), .SIZE_W(SW), .NUM_IRQ(NI)) u0 (.*);

    int n_cmp = 0, n_bad = 0;
    int n_sh = 0, n_dh = 0, n_sd = 0, n_dd = 0, n_blk = 0, n_ab = 0;
    logic [AW+7:0] exp_q[$];
    bit finished = 0;

    int m_sp = 0, m_dp = 0, m_bc = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic m_clear();
        m_sp = 0; m_dp = 0; m_bc = 0;
    endtask

    task automatic clr_cnt();
        n_sh = 0; n_dh = 0; n_sd = 0; n_dd = 0; n_blk = 0; n_ab = 0;
    endtask

    // driver side of the scoreboard: expected writes from the requirements
    task automatic exp_bytes(int n);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] wa;
            logic [7:0]    wd;
            int            blen;
            wa = AW'(int'(dst_base) + m_dp);
            wd = 8'(int'(src_base) + m_sp) ^ 8'h5A;
            exp_q.push_back({wa, wd});
            m_sp++; if (m_sp == int'(src_size)) m_sp = 0;
            m_dp++; if (m_dp == int'(dst_size)) m_dp = 0;
            m_bc++;
            blen = (src_size > dst_size) ? int'(src_size) : int'(dst_size);
            if (m_bc == blen) m_clear();
        end
    endtask

    task automatic pulse_force();
        force_go = 1; tick(1); force_go = 0;
    endtask

    task automatic pulse_arm();
        ch_arm = 1; tick(1); ch_arm = 0;
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (src_half) n_sh++;
            if (dst_half) n_dh++;
            if (src_done) n_sd++;
            if (dst_done) n_dd++;
            if (blk_done) n_blk++;
            if (abort_flag) n_ab++;
            if (mem_en) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R1 unexpected write: actual addr %0h expected none", mem_wr_addr);
                end else begin
                    logic [AW+7:0] e;
                    e = exp_q.pop_front();
                    if ({mem_wr_addr, mem_wr_data} != e) begin
                        n_bad++;
                        $display("FAIL R3 write: actual %0h/%0h expected %0h/%0h",
                                 mem_wr_addr, mem_wr_data, e[AW+7:8], e[7:0]);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        chk("R1 reset src_ptr", int'(src_ptr), 0);
        chk("R1 reset dst_ptr", int'(dst_ptr), 0);
        chk("R1 reset ch_enabled", int'(ch_enabled), 0);
        chk("R1 reset mem_en", int'(mem_en), 0);

        // R1: controller on, channel not armed -> no transfer
        ctl_on = 1;
        pulse_force(); tick(6);
        chk("R1 disarmed no move", int'(src_ptr), 0);

        // R2/R3/R5: first cell by force (held two cycles, second ignored)
        pulse_arm(); clr_cnt(); m_clear();
        exp_bytes(3);
        force_go = 1; tick(2); force_go = 0; tick(6);
        chk("R2 one cell per trigger queue", exp_q.size(), 0);
        chk("R3 src_ptr after cell", int'(src_ptr), 3);
        chk("R3 dst_ptr after cell", int'(dst_ptr), 3);
        chk("R5 src half pulse", n_sh, 1);
        chk("R5 dst half pulse", n_dh, 1);
        chk("R6 no done yet", n_dd, 0);

        // R2/R6/R7: second cell by irq, wraps and ends block, disarms
        clr_cnt(); start_sel = 3'd5; start_irq_en = 1;
        exp_bytes(3);
        irq_vec[5] = 1; tick(1); irq_vec[5] = 0; tick(6);
        chk("R2 irq start queue", exp_q.size(), 0);
        chk("R6 src done pulse", n_sd, 1);
        chk("R6 dst done pulse", n_dd, 1);
        chk("R7 blk_done pulse", n_blk, 1);
        chk("R7 src_ptr cleared", int'(src_ptr), 0);
        chk("R7 dst_ptr cleared", int'(dst_ptr), 0);
        chk("R7 disarmed", int'(ch_enabled), 0);

        // R1: trigger after disarm does nothing
        irq_vec[5] = 1; tick(1); irq_vec[5] = 0; tick(6);
        chk("R1 no move after disarm", int'(src_ptr), 0);
        start_irq_en = 0;

        // R7: auto-enable keeps channel armed
        auto_en = 1; cell_size = 6'd6; pulse_arm(); clr_cnt();
        exp_bytes(6);
        pulse_force(); tick(10);
        chk("R7 auto queue", exp_q.size(), 0);
        chk("R7 auto blk_done", n_blk, 1);
        chk("R7 auto stays armed", int'(ch_enabled), 1);

        // R11: pattern end with auto-enable
        pat_en = 1; pat_val = 8'h01 ^ 8'h5A; cell_size = 6'd4; clr_cnt();
        exp_bytes(2); m_clear();
        pulse_force(); tick(8);
        chk("R11 queue", exp_q.size(), 0);
        chk("R11 src_ptr", int'(src_ptr), 0);
        chk("R11 armed", int'(ch_enabled), 1);
        chk("R11 no abort", n_ab, 0);

        // R10: pattern abort without auto-enable
        auto_en = 0; clr_cnt();
        exp_bytes(2); m_clear();
        pulse_force(); tick(8);
        chk("R10 pattern queue", exp_q.size(), 0);
        chk("R10 pattern abort flag", n_ab, 1);
        chk("R10 pattern disarm", int'(ch_enabled), 0);
        chk("R10 pattern ptr", int'(dst_ptr), 0);
        pat_en = 0;

        // R10: abort strobe between cells
        cell_size = 6'd2; pulse_arm(); clr_cnt();
        exp_bytes(2);
        pulse_force(); tick(5);
        chk("R3 ptr before abort", int'(src_ptr), 2);
        abort_go = 1; tick(1); abort_go = 0; tick(2); m_clear();
        chk("R10 strobe ptr", int'(src_ptr), 0);
        chk("R10 strobe flag", n_ab, 1);
        chk("R10 strobe disarm", int'(ch_enabled), 0);

        // R10: abort irq mid-cell, in-flight transaction completes
        cell_size = 6'd4; abort_sel = 3'd2; abort_irq_en = 1; pulse_arm(); clr_cnt();
        exp_bytes(2); m_clear();
        pulse_force(); tick(1);
        irq_vec[2] = 1; tick(1); irq_vec[2] = 0; tick(4);
        chk("R10 irq abort queue", exp_q.size(), 0);
        chk("R10 irq abort flag", n_ab, 1);
        chk("R10 irq abort ptr", int'(dst_ptr), 0);
        abort_irq_en = 0;

        // R10: address error on second transaction
        pulse_arm(); clr_cnt(); err_addr = 16'h0101; err_arm = 1;
        exp_bytes(2); m_clear();
        pulse_force(); tick(8);
        chk("R10 err queue", exp_q.size(), 0);
        chk("R10 err flag", n_ab, 1);
        chk("R10 err disarm", int'(ch_enabled), 0);
        err_arm = 0;

        // R12: abort while suspended keeps offsets
        pulse_arm(); clr_cnt();
        exp_bytes(2);
        pulse_force(); tick(2);
        ctl_susp = 1; tick(2);
        abort_go = 1; tick(1); abort_go = 0; tick(2);
        chk("R12 src kept", int'(src_ptr), 2);
        chk("R12 dst kept", int'(dst_ptr), 2);
        chk("R12 flag", n_ab, 1);
        chk("R12 disarm", int'(ch_enabled), 0);
        ctl_susp = 0; tick(3);
        chk("R4 hold after resume", int'(src_ptr), 2);

        // R9: source base rewrite clears only source offset
        src_base_wr = 1; tick(1); src_base_wr = 0; tick(1);
        chk("R9 src cleared", int'(src_ptr), 0);
        chk("R9 dst kept", int'(dst_ptr), 2);

        // R8: controller off clears offsets
        ctl_on = 0; tick(2);
        chk("R8 dst cleared", int'(dst_ptr), 0);
        ctl_on = 1; m_clear(); tick(1);

        // R13: disarm mid-cell stalls, re-arm resumes
        pulse_arm(); clr_cnt();
        exp_bytes(4);
        pulse_force();
        ch_disarm = 1; tick(1); ch_disarm = 0; tick(5);
        chk("R13 stalled ptr", int'(src_ptr), 1);
        chk("R13 stalled queue", exp_q.size(), 3);
        chk("R4 stall hold dst", int'(dst_ptr), 1);
        pulse_arm(); tick(6);
        chk("R13 resumed queue", exp_q.size(), 0);
        chk("R13 resumed src", int'(src_ptr), 4);
        chk("R6 dst wrapped", int'(dst_ptr), 0);
        chk("R13 armed", int'(ch_enabled), 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule